// File: doc/BRIEF.md
# Real-Time Clock Write-Protect Synchronizer

This block sits between a fast register bus and the slow 32 kHz counter core of a real-time clock. Software writes control bits, count values, alarm values, trim and oscillator settings through a simple write port and reads them back at any time through a combinational read port. Permission rules decide whether each write is taken. They depend on the run-enable, unlock and alarm-enable bits and on a hardware busy flag. A write that is refused leaves every register untouched and sets a sticky reject flag.

Writes that the slow domain must see set busy: count writes, trim writes, and changes to the run-enable or either alarm-enable bit. The new values are copied into a set of synchronized outputs at the next 32 kHz tick, and busy then clears. The 32 kHz and 4 kHz edges arrive as single-cycle tick enables on the fast clock, so the block has one clock domain.

A three-state machine controls the copy:
- `ST_BOOT` is entered at reset, with busy high.
- `ST_IDLE` has busy low.
- `ST_PEND` holds one pending transfer, with busy high.

Its transitions are:
- boot-sync: `ST_BOOT` to `ST_IDLE` on a tick.
- start: `ST_IDLE` to `ST_PEND` on a write that is taken and needs a transfer.
- transfer: `ST_PEND` to `ST_IDLE` on a tick.
- Otherwise the state holds.

Top module: `rtc_wprot_sync`

## Requirements
- R1: After reset, busy is 1 and all synchronized outputs are 0. Busy stays 1 until the first 32 kHz tick, which performs the boot transfer.
- R2: From idle, busy rises in the cycle after any of these writes is taken: a count write, a trim write, or a control write that changes run (bit 0), alarm-of-day enable (bit 1) or sub-second alarm enable (bit 2). A control write that changes only unlock (bit 3) or the reject-clear bit (bit 4) leaves busy at 0.
- R3: While busy is 1, writes to the count registers, the trim register and control bits 0 to 2 are ignored and set the reject flag.
- R4: Busy clears in the cycle after a 32 kHz tick that arrives while it is high. On that same edge the synchronized outputs take the shadow values and `sync_load` pulses for one cycle. With ticks present, busy never spans two 4 kHz ticks.
- R5: A control write that clears run is taken only when unlock is already 1. Setting run needs only busy to be 0.
- R6: The seconds count (address 1) and sub-second count (address 2) accept writes only while run is 0 and busy is 0.
- R7: The alarm-of-day register (address 3) and the sub-second alarm register (address 4) accept a write only while their matching enable bit is 0. Busy does not affect them.
- R8: The trim register (address 5) and the oscillator register (address 6) accept writes only while unlock is 1 and busy is 0. An oscillator write does not set busy.
- R9: The reject flag (control bit 4) is sticky. A control write with bit 4 set clears it, and a rejection in the same cycle wins.
- R10: Every register reads at any time. The control register (address 0) reads run, alarm-of-day enable, sub-second enable, unlock, reject and busy in bits 0 to 5. Fields narrower than the bus keep the low bits of a write and read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Active-low reset |
| tick_32k | input | 1 | One-cycle pulse per 32 kHz edge |
| tick_4k | input | 1 | One-cycle pulse per 4 kHz edge |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | DATA_W | Read data (combinational) |
| busy | output | 1 | Transfer to slow domain pending |
| wr_reject | output | 1 | Sticky write-refused flag |
| alm_tod_q | output | CNT_W | Alarm-of-day register |
| alm_ss_q | output | SUB_W | Sub-second alarm register |
| osc_q | output | OSC_W | Oscillator control register |
| sync_run | output | 1 | Synchronized run enable |
| sync_tod_en | output | 1 | Synchronized alarm-of-day enable |
| sync_ss_en | output | 1 | Synchronized sub-second alarm enable |
| sync_sec | output | CNT_W | Synchronized seconds count |
| sync_sub | output | SUB_W | Synchronized sub-second count |
| sync_trim | output | TRIM_W | Synchronized trim |
| sync_load | output | 1 | One-cycle pulse on each transfer |

## Verification
The bench builds the block with a 16-bit bus and 16-bit seconds fields, and with sub-second, trim and oscillator fields of 8, 6 and 5 bits. Writing all-ones into the trim and oscillator registers therefore shows truncation and zero-extension on readback. The bench can hold back the 32 kHz tick, which keeps the machine in `ST_PEND` for many cycles. Writes blocked by busy, alarm writes taken during busy, and the transfer edge once ticks resume can all be seen at the ports.

// File: rtl/rtc_wp_pkg.sv
package rtc_wp_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_SEC     = 3'd1;
    localparam logic [ADDR_W-1:0] A_SUB     = 3'd2;
    localparam logic [ADDR_W-1:0] A_ALM_TOD = 3'd3;
    localparam logic [ADDR_W-1:0] A_ALM_SS  = 3'd4;
    localparam logic [ADDR_W-1:0] A_TRIM    = 3'd5;
    localparam logic [ADDR_W-1:0] A_OSC     = 3'd6;

    localparam int B_RUN  = 0;
    localparam int B_TOD  = 1;
    localparam int B_SS   = 2;
    localparam int B_UNL  = 3;
    localparam int B_REJ  = 4;
    localparam int B_BUSY = 5;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_IDLE = 2'd1,
        ST_PEND = 2'd2
    } sync_state_e;
endpackage

// File: rtl/rtc_wp_gate.sv
module rtc_wp_gate
    import rtc_wp_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              new_run,
    input  logic              new_tod,
    input  logic              new_ss,
    input  logic              busy,
    input  logic              run_q,
    input  logic              tod_q,
    input  logic              ss_q,
    input  logic              unl_q,
    output logic              acc_prot,
    output logic              acc_sec,
    output logic              acc_sub,
    output logic              acc_alm_tod,
    output logic              acc_alm_ss,
    output logic              acc_trim,
    output logic              acc_osc,
    output logic              rejected,
    output logic              start_sync
);
    logic sel_ctrl, sel_sec, sel_sub, sel_tod, sel_ss, sel_trim, sel_osc;
    logic prot_diff, ctrl_ok, cnt_ok, unl_ok;

    always_comb begin
        sel_ctrl = wr_en && (wr_addr == A_CTRL);
        sel_sec  = wr_en && (wr_addr == A_SEC);
        sel_sub  = wr_en && (wr_addr == A_SUB);
        sel_tod  = wr_en && (wr_addr == A_ALM_TOD);
        sel_ss   = wr_en && (wr_addr == A_ALM_SS);
        sel_trim = wr_en && (wr_addr == A_TRIM);
        sel_osc  = wr_en && (wr_addr == A_OSC);

        prot_diff = (new_run != run_q) || (new_tod != tod_q) || (new_ss != ss_q);
        // stopping the counter needs a prior unlock
        ctrl_ok   = !busy && (!(run_q && !new_run) || unl_q);
        cnt_ok    = !busy && !run_q;
        unl_ok    = !busy && unl_q;

        acc_prot    = sel_ctrl && prot_diff && ctrl_ok;
        acc_sec     = sel_sec  && cnt_ok;
        acc_sub     = sel_sub  && cnt_ok;
        acc_alm_tod = sel_tod  && !tod_q;
        acc_alm_ss  = sel_ss   && !ss_q;
        acc_trim    = sel_trim && unl_ok;
        acc_osc     = sel_osc  && unl_ok;

        rejected = (sel_ctrl && prot_diff && !ctrl_ok)
                 || ((sel_sec || sel_sub) && !cnt_ok)
                 || (sel_tod && tod_q) || (sel_ss && ss_q)
                 || ((sel_trim || sel_osc) && !unl_ok);

        start_sync = acc_prot || acc_sec || acc_sub || acc_trim;
    end
endmodule

// File: rtl/rtc_wp_fsm.sv
module rtc_wp_fsm
    import rtc_wp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_32k,
    input  logic tick_4k,
    input  logic start_sync,
    output logic busy,
    output logic xfer
);
    sync_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: if (tick_32k)   state_d = ST_IDLE;
            ST_IDLE: if (start_sync) state_d = ST_PEND;
            ST_PEND: if (tick_32k)   state_d = ST_IDLE;
            default:                 state_d = ST_BOOT;
        endcase
    end

    always_comb begin
        busy = (state_q != ST_IDLE);
        xfer = busy && tick_32k;
    end

    // 4 kHz ticks seen during the current busy span
    logic [1:0] span_4k_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             span_4k_q <= 2'd0;
        else if (!busy)                         span_4k_q <= 2'd0;
        else if (tick_4k && span_4k_q != 2'd3)  span_4k_q <= span_4k_q + 2'd1;
    end

    p_boot_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_BOOT) |=> (state_q != ST_BOOT));
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_sync && state_q == ST_IDLE) |=> busy);
    p_tick_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tick_32k) |=> !busy);
    p_span_4k_r4: assert property (@(posedge clk) disable iff (!rst_n)
        span_4k_q < 2'd2);
endmodule

// File: rtl/rtc_wp_xfer.sv
module rtc_wp_xfer #(
    parameter int CNT_W  = 32,
    parameter int SUB_W  = 12,
    parameter int TRIM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer,
    input  logic              run_q,
    input  logic              tod_q,
    input  logic              ss_q,
    input  logic [CNT_W-1:0]  sec_q,
    input  logic [SUB_W-1:0]  sub_q,
    input  logic [TRIM_W-1:0] trim_q,
    output logic              sync_run,
    output logic              sync_tod_en,
    output logic              sync_ss_en,
    output logic [CNT_W-1:0]  sync_sec,
    output logic [SUB_W-1:0]  sync_sub,
    output logic [TRIM_W-1:0] sync_trim,
    output logic              sync_load
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_run    <= 1'b0;
            sync_tod_en <= 1'b0;
            sync_ss_en  <= 1'b0;
            sync_sec    <= '0;
            sync_sub    <= '0;
            sync_trim   <= '0;
            sync_load   <= 1'b0;
        end else begin
            sync_load <= xfer;
            if (xfer) begin
                sync_run    <= run_q;
                sync_tod_en <= tod_q;
                sync_ss_en  <= ss_q;
                sync_sec    <= sec_q;
                sync_sub    <= sub_q;
                sync_trim   <= trim_q;
            end
        end
    end

    p_sync_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> ($stable(sync_sec) && $stable(sync_trim) && $stable(sync_run)));
endmodule

// File: rtl/rtc_wprot_sync.sv
module rtc_wprot_sync
    import rtc_wp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int SUB_W  = 12,
    parameter int TRIM_W = 8,
    parameter int OSC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic              tick_4k,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              wr_reject,
    output logic [CNT_W-1:0]  alm_tod_q,
    output logic [SUB_W-1:0]  alm_ss_q,
    output logic [OSC_W-1:0]  osc_q,
    output logic              sync_run,
    output logic              sync_tod_en,
    output logic              sync_ss_en,
    output logic [CNT_W-1:0]  sync_sec,
    output logic [SUB_W-1:0]  sync_sub,
    output logic [TRIM_W-1:0] sync_trim,
    output logic              sync_load
);
    localparam int CTRL_W = B_BUSY + 1;

    logic run_q, tod_q, ss_q, unl_q;
    logic [CNT_W-1:0]  sec_q;
    logic [SUB_W-1:0]  sub_q;
    logic [TRIM_W-1:0] trim_q;

    logic acc_prot, acc_sec, acc_sub, acc_alm_tod, acc_alm_ss, acc_trim, acc_osc;
    logic rejected, start_sync, xfer, ctrl_wr;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

    rtc_wp_gate u_gate (
        .wr_en(wr_en), .wr_addr(wr_addr),
        .new_run(wr_data[B_RUN]), .new_tod(wr_data[B_TOD]), .new_ss(wr_data[B_SS]),
        .busy(busy), .run_q(run_q), .tod_q(tod_q), .ss_q(ss_q), .unl_q(unl_q),
        .acc_prot(acc_prot), .acc_sec(acc_sec), .acc_sub(acc_sub),
        .acc_alm_tod(acc_alm_tod), .acc_alm_ss(acc_alm_ss),
        .acc_trim(acc_trim), .acc_osc(acc_osc),
        .rejected(rejected), .start_sync(start_sync)
    );

    rtc_wp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .tick_4k(tick_4k),
        .start_sync(start_sync), .busy(busy), .xfer(xfer)
    );

    rtc_wp_xfer #(.CNT_W(CNT_W), .SUB_W(SUB_W), .TRIM_W(TRIM_W)) u_xfer (
        .clk(clk), .rst_n(rst_n), .xfer(xfer),
        .run_q(run_q), .tod_q(tod_q), .ss_q(ss_q),
        .sec_q(sec_q), .sub_q(sub_q), .trim_q(trim_q),
        .sync_run(sync_run), .sync_tod_en(sync_tod_en), .sync_ss_en(sync_ss_en),
        .sync_sec(sync_sec), .sync_sub(sync_sub), .sync_trim(sync_trim),
        .sync_load(sync_load)
    );

    // shadow registers on the bus side
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0; tod_q <= 1'b0; ss_q <= 1'b0; unl_q <= 1'b0;
            sec_q <= '0; sub_q <= '0; trim_q <= '0;
            alm_tod_q <= '0; alm_ss_q <= '0; osc_q <= '0;
            wr_reject <= 1'b0;
        end else begin
            if (acc_prot) begin
                run_q <= wr_data[B_RUN];
                tod_q <= wr_data[B_TOD];
                ss_q  <= wr_data[B_SS];
            end
            if (ctrl_wr)     unl_q     <= wr_data[B_UNL];
            if (acc_sec)     sec_q     <= wr_data[CNT_W-1:0];
            if (acc_sub)     sub_q     <= wr_data[SUB_W-1:0];
            if (acc_trim)    trim_q    <= wr_data[TRIM_W-1:0];
            if (acc_alm_tod) alm_tod_q <= wr_data[CNT_W-1:0];
            if (acc_alm_ss)  alm_ss_q  <= wr_data[SUB_W-1:0];
            if (acc_osc)     osc_q     <= wr_data[OSC_W-1:0];
            if (rejected)                        wr_reject <= 1'b1;
            else if (ctrl_wr && wr_data[B_REJ])  wr_reject <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL:    rd_data = DATA_W'({busy, wr_reject, unl_q, ss_q, tod_q, run_q});
            A_SEC:     rd_data = DATA_W'(sec_q);
            A_SUB:     rd_data = DATA_W'(sub_q);
            A_ALM_TOD: rd_data = DATA_W'(alm_tod_q);
            A_ALM_SS:  rd_data = DATA_W'(alm_ss_q);
            A_TRIM:    rd_data = DATA_W'(trim_q);
            A_OSC:     rd_data = DATA_W'(osc_q);
            default:   rd_data = '0;
        endcase
    end

    initial assert (CTRL_W <= DATA_W && CNT_W <= DATA_W && SUB_W <= DATA_W);

    p_blocked_sec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_SEC && busy) |=> ($stable(sec_q) && wr_reject));
    p_clear_needs_unlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !unl_q) |=> run_q);
    p_count_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_SUB && run_q) |=> $stable(sub_q));
    p_alarm_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_ALM_TOD && tod_q) |=> $stable(alm_tod_q));
    p_trim_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_TRIM && !unl_q) |=> $stable(trim_q));
    p_osc_no_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && wr_addr == A_OSC) |=> !busy);
    p_reject_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_reject && !ctrl_wr) |=> wr_reject);
endmodule

// File: tb/rtc_wprot_sync_tb.sv
`timescale 1ns/1ps
module rtc_wprot_sync_tb_top;
    localparam int DW = 16, CW = 16, SW = 8, TW = 6, OW = 5;

    logic clk = 1'b0, rst_n = 1'b0, tick_32k = 1'b0, tick_4k = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic busy, wr_reject, sync_run, sync_tod_en, sync_ss_en, sync_load;
    logic [CW-1:0] alm_tod_q, sync_sec;
    logic [SW-1:0] alm_ss_q, sync_sub;
    logic [OW-1:0] osc_q;
    logic [TW-1:0] sync_trim;

    int total = 0, bad = 0;
    logic hold = 1'b0;

    always #5 clk = ~clk;

    rtc_wprot_sync #(.DATA_W(DW), .CNT_W(CW), .SUB_W(SW), .TRIM_W(TW), .OSC_W(OW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .tick_4k(tick_4k),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .wr_reject(wr_reject),
        .alm_tod_q(alm_tod_q), .alm_ss_q(alm_ss_q), .osc_q(osc_q),
        .sync_run(sync_run), .sync_tod_en(sync_tod_en), .sync_ss_en(sync_ss_en),
        .sync_sec(sync_sec), .sync_sub(sync_sub), .sync_trim(sync_trim),
        .sync_load(sync_load)
    );

    // tick generator: 32 kHz every 8 cycles, 4 kHz every 64
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            cnt++;
            tick_32k = !hold && (cnt % 8 == 0);
            tick_4k  = (cnt % 64 == 0);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        @(negedge clk);
        chk("R1 busy at reset", busy, 1);
        chk("R1 sync_run at reset", sync_run, 0);
        chk("R1 sync_sec at reset", sync_sec, 0);
        rd(3'd0, v);
        chk("R10 ctrl busy bit", v, 16'h20);
        wait_idle();
        chk("R1 boot sync done", busy, 0);
    endtask

    task automatic t_ctrl_run();
        logic [DW-1:0] v;
        hold = 1'b1;
        wr(3'd0, 16'h01);
        chk("R2 busy after run set", busy, 1);
        wr(3'd0, 16'h00);
        rd(3'd0, v);
        chk("R3 ctrl write blocked while busy", v, 16'h31);
        hold = 1'b0;
        wait_idle();
        chk("R4 sync_run loaded", sync_run, 1);
        wr(3'd0, 16'h11);
        chk("R2 no busy without change", busy, 0);
        rd(3'd0, v);
        chk("R9 reject cleared", v, 16'h01);
    endtask

    task automatic t_run_clear();
        logic [DW-1:0] v;
        wr(3'd0, 16'h00);
        rd(3'd0, v);
        chk("R5 clear run refused when locked", v, 16'h11);
        wr(3'd0, 16'h19);
        chk("R2 unlock change no busy", busy, 0);
        wr(3'd0, 16'h08);
        chk("R5 clear run accepted", busy, 1);
        wait_idle();
        chk("R5 sync_run cleared", sync_run, 0);
    endtask

    task automatic t_count();
        logic [DW-1:0] v;
        hold = 1'b1;
        wr(3'd1, 16'hABCD);
        chk("R6 count write sets busy", busy, 1);
        wr(3'd2, 16'h77);
        rd(3'd2, v);
        chk("R3 sub write blocked while busy", v, 0);
        chk("R3 reject set", wr_reject, 1);
        hold = 1'b0;
        wait_idle();
        chk("R4 sync_sec loaded", sync_sec, 16'hABCD);
        chk("R4 sync_sub unchanged", sync_sub, 0);
        wr(3'd0, 16'h19);
        wait_idle();
        wr(3'd1, 16'h1234);
        rd(3'd1, v);
        chk("R6 sec write refused while running", v, 16'hABCD);
    endtask

    task automatic t_alarm();
        logic [DW-1:0] v;
        wr(3'd0, 16'h1B);
        wait_idle();
        wr(3'd3, 16'h55);
        rd(3'd3, v);
        chk("R7 alarm write refused while enabled", v, 0);
        hold = 1'b1;
        wr(3'd0, 16'h19);
        wr(3'd3, 16'h55);
        rd(3'd3, v);
        chk("R7 alarm write taken during busy", v, 16'h55);
        wr(3'd4, 16'h21);
        chk("R7 ss alarm taken", alm_ss_q, 8'h21);
        hold = 1'b0;
        wait_idle();
        chk("R4 sync_tod_en cleared", sync_tod_en, 0);
    endtask

    task automatic t_trim();
        logic [DW-1:0] v;
        wr(3'd0, 16'h11);
        chk("R2 lock change no busy", busy, 0);
        wr(3'd5, 16'h03);
        rd(3'd5, v);
        chk("R8 trim refused when locked", v, 0);
        wr(3'd0, 16'h19);
        wr(3'd5, 16'h2A);
        chk("R8 trim sets busy", busy, 1);
        wait_idle();
        chk("R8 sync_trim loaded", sync_trim, 6'h2A);
        wr(3'd6, 16'h15);
        chk("R8 osc write no busy", busy, 0);
        chk("R8 osc taken", osc_q, 5'h15);
        wr(3'd5, 16'hFFFF);
        rd(3'd5, v);
        chk("R10 trim truncated", v, 16'h3F);
        wait_idle();
        wr(3'd6, 16'hFFFF);
        rd(3'd6, v);
        chk("R10 osc truncated", v, 16'h1F);
    endtask

    task automatic t_busy_hold();
        int n;
        hold = 1'b1;
        wr(3'd5, 16'h11);
        repeat (30) @(negedge clk);
        chk("R4 busy held without tick", busy, 1);
        chk("R4 sync_trim old while pending", sync_trim, 6'h3F);
        hold = 1'b0;
        n = 0;
        while (busy && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk("R4 busy cleared by tick", busy, 0);
        chk("R4 sync_load pulse", sync_load, 1);
        chk("R4 sync_trim new", sync_trim, 6'h11);
        @(negedge clk);
        chk("R4 sync_load one cycle", sync_load, 0);
    endtask

    initial begin
        #200_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_run();
        t_run_clear();
        t_count();
        t_alarm();
        t_trim();
        t_busy_hold();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule